// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This unit decides the outcome of a two-byte conditional relative branch for an 8-bit processor core with a 16-bit address space. Each evaluation is qualified by a one-cycle strobe carrying the opcode byte, the four condition flags (negative, overflow, carry, zero), the address of the opcode and a signed 8-bit displacement. One clock later it presents a registered result: whether the branch is taken, the address execution continues at, and how many machine cycles the branch costs.

The sequential address is the opcode address plus 2, the length of every branch. A taken branch adds the sign-extended displacement to that sequential address, wrapping modulo 65536. The cycle cost depends only on the outcome and on a page comparison: 2 when not taken, 3 when taken, and 4 when taken to a 256-byte page other than the page of the sequential address. Bytes that are not branch opcodes are flagged as illegal and never yield a taken result.

Top module: `brc_resolve_unit`

## Requirements
- R1: A result is registered on the clock edge that samples `valid_i` high; `done_o` is 1 in the cycle after each strobe and 0 in the cycle after any cycle with `valid_i` low.
- R2: Opcode bits 7:6 select the tested flag (00 negative, 01 overflow, 10 carry, 11 zero) and bit 5 gives the value the flag must have; the branch is taken exactly when the selected flag equals bit 5, and the other three flags have no effect.
- R3: A byte is a branch opcode exactly when its bits 4:0 are 10000 (0x10, 0x30, 0x50, 0x70, 0x90, 0xB0, 0xD0, 0xF0); any other byte gives `illegal_o`=1, `taken_o`=0, `cycles_o`=0 and `next_pc_o` equal to the opcode address.
- R4: A branch that is not taken gives `next_pc_o` = opcode address + 2 and `cycles_o` = 2.
- R5: A taken branch gives `next_pc_o` = opcode address + 2 + sign-extended displacement, modulo 65536 (displacement 0x06 lands 8 bytes past the opcode, 0xFA lands 4 bytes before it).
- R6: A taken branch costs 3 cycles when the target's upper address byte equals that of opcode address + 2, and 4 cycles otherwise, including when the sum wraps across 0xFFFF/0x0000.
- R7: A taken branch with displacement 0 costs exactly 3 cycles, even when the opcode itself sits on the previous page.
- R8: While `valid_i` is low, `taken_o`, `illegal_o`, `next_pc_o` and `cycles_o` keep their last values.
- R9: Synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Strobe qualifying one evaluation |
| opcode_i | input | 8 | Branch opcode byte |
| flag_n_i | input | 1 | Negative flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_c_i | input | 1 | Carry flag |
| flag_z_i | input | 1 | Zero flag |
| pc_i | input | 16 | Address of the opcode byte |
| disp_i | input | 8 | Signed displacement |
| done_o | output | 1 | Result valid, one cycle after the strobe |
| taken_o | output | 1 | Branch taken |
| illegal_o | output | 1 | Opcode is not a branch |
| next_pc_o | output | 16 | Address execution continues at |
| cycles_o | output | 3 | Machine cycles consumed |

## Verification
All state is the single result register, so a wrong flag selection, a missing sign extension or a page compare on the wrong address shows at `taken_o`, `next_pc_o` or `cycles_o` in the very cycle after the offending strobe. The vectors place targets on both sides of page edges, forward and backward, across the 16-bit wrap and with a zero displacement from the last byte of a page, so an off-by-two in the sequential address or a compare against the opcode's own page changes a cycle count immediately. A faulty hold path appears as results changing in idle cycles after a strobe.

// File: rtl/brc_pkg.sv
package brc_pkg;

    // Widths shared across the resolver
    localparam int OP_W      = 8;
    localparam int CYC_W     = 3;
    localparam int BR_LEN    = 2;

    // Cycle costs
    localparam int CYC_NOT_TAKEN = 2;
    localparam int CYC_TAKEN     = 3;
    localparam int CYC_CROSS_ADD = 1;

    // Low opcode bits that mark a conditional branch
    localparam logic [4:0] BR_LOW_PATTERN = 5'b10000;

    typedef enum logic [1:0] {
        SEL_NEG = 2'b00,
        SEL_OVF = 2'b01,
        SEL_CRY = 2'b10,
        SEL_ZER = 2'b11
    } flag_sel_e;

    typedef struct packed {
        logic neg;
        logic ovf;
        logic cry;
        logic zer;
    } flags_t;

    typedef struct packed {
        logic      is_branch;
        flag_sel_e sel;
        logic      want;
    } br_decode_t;

    function automatic br_decode_t decode_opcode(input logic [OP_W-1:0] op);
        br_decode_t d;
        d.is_branch = (op[4:0] == BR_LOW_PATTERN);
        d.sel       = flag_sel_e'(op[7:6]);
        d.want      = op[5];
        return d;
    endfunction

    function automatic logic pick_flag(input flags_t f, input flag_sel_e s);
        logic v;
        case (s)
            SEL_NEG: v = f.neg;
            SEL_OVF: v = f.ovf;
            SEL_CRY: v = f.cry;
            default: v = f.zer;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  flags_t          flags,
    output logic            legal,
    output logic            taken
);
    br_decode_t dec;

    always_comb begin
        dec   = decode_opcode(opcode);
        legal = dec.is_branch;
        taken = dec.is_branch && (pick_flag(flags, dec.sel) == dec.want);
    end
endmodule

// File: rtl/brc_target_calc.sv
module brc_target_calc
    import brc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8,
    parameter int OFS_W  = 8
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] seq_pc,
    output logic [ADDR_W-1:0] target,
    output logic              page_cross
);
    localparam int PAGE_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] disp_ext;

    generate
        if (DISP_W < ADDR_W) begin : g_sext
            assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[ADDR_W-1:0];
        end
    endgenerate

    logic [PAGE_W-1:0] seq_page;
    logic [PAGE_W-1:0] tgt_page;

    always_comb begin
        seq_pc     = pc + ADDR_W'(BR_LEN);
        target     = seq_pc + disp_ext;
        seq_page   = seq_pc[ADDR_W-1:OFS_W];
        tgt_page   = target[ADDR_W-1:OFS_W];
        page_cross = (seq_page != tgt_page);
    end
endmodule

// File: rtl/brc_cycle_calc.sv
module brc_cycle_calc
    import brc_pkg::*;
(
    input  logic             legal,
    input  logic             taken,
    input  logic             page_cross,
    output logic [CYC_W-1:0] cycles
);
    always_comb begin
        if (!legal) begin
            cycles = '0;
        end else if (!taken) begin
            cycles = CYC_W'(CYC_NOT_TAKEN);
        end else if (page_cross) begin
            cycles = CYC_W'(CYC_TAKEN + CYC_CROSS_ADD);
        end else begin
            cycles = CYC_W'(CYC_TAKEN);
        end
    end
endmodule

// File: rtl/brc_resolve_unit.sv
module brc_resolve_unit
    import brc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8,
    parameter int OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [OP_W-1:0]   opcode_i,
    input  logic              flag_n_i,
    input  logic              flag_v_i,
    input  logic              flag_c_i,
    input  logic              flag_z_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic              done_o,
    output logic              taken_o,
    output logic              illegal_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic [CYC_W-1:0]  cycles_o
);
    flags_t            flags;
    logic              legal;
    logic              cond_taken;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] target;
    logic              page_cross;
    logic [CYC_W-1:0]  cycles_nx;
    logic [ADDR_W-1:0] next_pc_nx;

    assign flags = '{neg: flag_n_i, ovf: flag_v_i, cry: flag_c_i, zer: flag_z_i};

    brc_cond_eval i_cond (
        .opcode (opcode_i),
        .flags  (flags),
        .legal  (legal),
        .taken  (cond_taken)
    );

    brc_target_calc #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .OFS_W  (OFS_W)
    ) i_target (
        .pc         (pc_i),
        .disp       (disp_i),
        .seq_pc     (seq_pc),
        .target     (target),
        .page_cross (page_cross)
    );

    brc_cycle_calc i_cycles (
        .legal      (legal),
        .taken      (cond_taken),
        .page_cross (page_cross),
        .cycles     (cycles_nx)
    );

    always_comb begin
        if (!legal) begin
            next_pc_nx = pc_i;
        end else if (cond_taken) begin
            next_pc_nx = target;
        end else begin
            next_pc_nx = seq_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o    <= 1'b0;
            taken_o   <= 1'b0;
            illegal_o <= 1'b0;
            next_pc_o <= '0;
            cycles_o  <= '0;
        end else begin
            done_o <= valid_i;
            if (valid_i) begin
                taken_o   <= cond_taken;
                illegal_o <= !legal;
                next_pc_o <= next_pc_nx;
                cycles_o  <= cycles_nx;
            end
        end
    end
endmodule

// File: rtl/brc_resolve_chk.sv
module brc_resolve_chk
    import brc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic              done_o,
    input logic              taken_o,
    input logic              illegal_o,
    input logic [ADDR_W-1:0] next_pc_o,
    input logic [CYC_W-1:0]  cycles_o
);
    // Sequential address of the previous cycle's request, tracked separately
    logic [ADDR_W-1:0] seq_q;
    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= pc_i + ADDR_W'(2);
    end

    // R1
    done_follows_valid_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> done_o);

    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !done_o);

    // R3
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!taken_o && cycles_o == '0));

    // R4
    not_taken_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !taken_o && !illegal_o) |-> (cycles_o == CYC_W'(2) && next_pc_o == seq_q));

    // R6
    taken_cycles_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && taken_o) |-> (cycles_o == CYC_W'(3) || cycles_o == CYC_W'(4)));

    // R6
    same_page_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && taken_o) |->
            ((next_pc_o[ADDR_W-1:OFS_W] == seq_q[ADDR_W-1:OFS_W]) == (cycles_o == CYC_W'(3))));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(next_pc_o) && $stable(cycles_o) && $stable(taken_o) && $stable(illegal_o)));
endmodule

bind brc_resolve_unit brc_resolve_chk #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W)
) i_brc_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .pc_i      (pc_i),
    .done_o    (done_o),
    .taken_o   (taken_o),
    .illegal_o (illegal_o),
    .next_pc_o (next_pc_o),
    .cycles_o  (cycles_o)
);

// File: tb/test_brc_resolve_unit.sv
module test_brc_resolve_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 15;

    typedef struct packed {
        logic [7:0]  op;
        logic [3:0]  nvcz;
        logic [15:0] pc;
        logic [7:0]  disp;
        logic        tk;
        logic        il;
        logic [15:0] npc;
        logic [2:0]  cy;
    } vec_t;

    // Expected values worked by hand from the requirements
    localparam vec_t VECS [N_VEC] = '{
        '{8'h10, 4'b0000, 16'h1000, 8'h06, 1'b1, 1'b0, 16'h1008, 3'd3}, // R5 +6 -> opcode+8
        '{8'h30, 4'b0000, 16'h1000, 8'h06, 1'b0, 1'b0, 16'h1002, 3'd2}, // R4
        '{8'h50, 4'b0000, 16'h2000, 8'hFA, 1'b1, 1'b0, 16'h1FFC, 3'd4}, // R5 -6 -> opcode-4, R6
        '{8'h70, 4'b0100, 16'h2080, 8'hFA, 1'b1, 1'b0, 16'h207C, 3'd3}, // R2 overflow set
        '{8'h90, 4'b0010, 16'h3000, 8'h10, 1'b0, 1'b0, 16'h3002, 3'd2}, // R2 carry clear fails
        '{8'hB0, 4'b0010, 16'h30F0, 8'h20, 1'b1, 1'b0, 16'h3112, 3'd4}, // R6 forward cross
        '{8'hD0, 4'b0001, 16'h4000, 8'h00, 1'b0, 1'b0, 16'h4002, 3'd2}, // R2 zero clear fails
        '{8'hF0, 4'b0001, 16'h40FE, 8'h00, 1'b1, 1'b0, 16'h4100, 3'd3}, // R7 disp 0 off page end
        '{8'hF0, 4'b0001, 16'hFFFE, 8'h05, 1'b1, 1'b0, 16'h0005, 3'd3}, // R5 wrap forward
        '{8'h10, 4'b0000, 16'h0010, 8'h80, 1'b1, 1'b0, 16'hFF92, 3'd4}, // R6 wrap backward
        '{8'h4C, 4'b1111, 16'h5000, 8'h10, 1'b0, 1'b1, 16'h5000, 3'd0}, // R3
        '{8'h18, 4'b0000, 16'h5100, 8'h10, 1'b0, 1'b1, 16'h5100, 3'd0}, // R3
        '{8'hB0, 4'b1101, 16'h6000, 8'h7F, 1'b0, 1'b0, 16'h6002, 3'd2}, // R2 other flags ignored
        '{8'h30, 4'b1000, 16'h60FD, 8'h7F, 1'b1, 1'b0, 16'h617E, 3'd4}, // R6
        '{8'hD0, 4'b1110, 16'h7000, 8'h7E, 1'b1, 1'b0, 16'h7080, 3'd3}  // R2 zero clear passes
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [7:0]  opcode_i = '0;
    logic        flag_n_i = 1'b0, flag_v_i = 1'b0, flag_c_i = 1'b0, flag_z_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic [7:0]  disp_i = '0;
    logic        done_o, taken_o, illegal_o;
    logic [15:0] next_pc_o;
    logic [2:0]  cycles_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brc_resolve_unit i_brc_resolve_unit (
        .clk, .rst, .valid_i, .opcode_i,
        .flag_n_i, .flag_v_i, .flag_c_i, .flag_z_i,
        .pc_i, .disp_i, .done_o, .taken_o, .illegal_o, .next_pc_o, .cycles_o
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        valid_i  = 1'b1;
        opcode_i = v.op;
        {flag_n_i, flag_v_i, flag_c_i, flag_z_i} = v.nvcz;
        pc_i     = v.pc;
        disp_i   = v.disp;
        @(negedge clk);
        valid_i  = 1'b0;
    endtask

    task automatic check_vec(input string req, input vec_t v);
        check(req, "done",    32'(done_o),    32'(1'b1));
        check(req, "taken",   32'(taken_o),   32'(v.tk));
        check(req, "illegal", 32'(illegal_o), 32'(v.il));
        check(req, "next_pc", 32'(next_pc_o), 32'(v.npc));
        check(req, "cycles",  32'(cycles_o),  32'(v.cy));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "done",    32'(done_o),    0);
        check("R9", "taken",   32'(taken_o),   0);
        check("R9", "illegal", 32'(illegal_o), 0);
        check("R9", "next_pc", 32'(next_pc_o), 0);
        check("R9", "cycles",  32'(cycles_o),  0);
        rst = 1'b0;

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < N_VEC; i++) begin
            drive(VECS[i]);
            check_vec($sformatf("vec%0d", i), VECS[i]);
        end

        // R1 and R8: idle cycles after a strobe, inputs changed but unqualified
        drive(VECS[5]);
        opcode_i = 8'h10; pc_i = 16'h0000; disp_i = 8'h01;
        @(negedge clk);
        check("R1", "done drops when idle", 32'(done_o), 0);
        check("R8", "next_pc held", 32'(next_pc_o), 32'(VECS[5].npc));
        check("R8", "cycles held",  32'(cycles_o),  32'(VECS[5].cy));
        check("R8", "taken held",   32'(taken_o),   32'(VECS[5].tk));

        // R1: back-to-back strobes each give a result one cycle later
        @(negedge clk);
        valid_i = 1'b1; opcode_i = VECS[0].op; {flag_n_i, flag_v_i, flag_c_i, flag_z_i} = VECS[0].nvcz;
        pc_i = VECS[0].pc; disp_i = VECS[0].disp;
        @(negedge clk);
        check_vec("R1 b2b first", VECS[0]);
        opcode_i = VECS[10].op; {flag_n_i, flag_v_i, flag_c_i, flag_z_i} = VECS[10].nvcz;
        pc_i = VECS[10].pc; disp_i = VECS[10].disp;
        @(negedge clk);
        valid_i = 1'b0;
        check_vec("R1 b2b second", VECS[10]);

        // R9: reset after activity clears outputs
        rst = 1'b1;
        @(negedge clk);
        check("R9", "next_pc after reset", 32'(next_pc_o), 0);
        check("R9", "illegal after reset", 32'(illegal_o), 0);
        rst = 1'b0;

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule